// File: doc/BRIEF.md
# Configurable Dual-Port RAM

This block is an on-chip word memory with two independent ports, each with its own address, read data and optional write path. The word width, the number of words and an optional initial image are parameters. Every port is tailored on its own by parameters:

- whether it can write at all;
- the sub-word size used for byte-style masked writes;
- whether its read output is registered or combinational;
- whether it has a read enable;
- what its registered output shows in a cycle where that same port writes.

It is meant as a generic storage element inside a larger datapath, where one port is often a writer and the other a reader, or both are full read/write ports. The image lives in a packed vector parameter and is loaded into the array by the synchronous active-low reset. Addresses at or beyond the depth are treated as holes. If a nonzero sub-word size does not divide the word width, elaboration stops with an error.

Top module: `dual_port_ram`

## Requirements
- R1: While rst_n is low at a rising edge, every registered read output becomes zero, word i of the array (i < INIT_LEN) is loaded from INIT_VEC bits [i*WIDTH +: WIDTH], and all other words are loaded with zero.
- R2: A port with sub-word size 0 has a 1-bit write enable, and a write with it set replaces the whole word.
- R3: A port with nonzero sub-word size G has WIDTH/G write-enable bits. Bit k writes only word bits [k*G +: G], and the other bits of the word keep their contents.
- R4: A registered read port updates its output at the first rising edge after the address is presented, and it holds the output between edges.
- R5: A combinational read port shows the current contents of the addressed word with no clock, including a write from either port as soon as the edge that performs it has passed.
- R6: On a registered port with a read enable, the output holds while that enable is low. A port built without a read enable reads at every edge whatever its rd_en input is.
- R7: In read-before-write mode, a registered port that writes an address returns that word's contents from before the write.
- R8: In write-through mode, a registered port that writes an address returns its own write data in the enabled sub-words and the old contents in the rest.
- R9: In hold mode, a registered port keeps its previous output in any cycle in which it writes.
- R10: A read of an address at or above DEPTH returns zero. A write to such an address is dropped and does not alias onto any stored word.
- R11: When both ports write the same word at one edge, port 0 wins every sub-word it enables. Sub-words enabled only by port 1 take port 1's data.
- R12: A registered read on one port of the word that the other port writes at the same edge returns the old contents.
- R13: A port built without write capability ignores its wr_en and wdata inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial image |
| p0_addr | input | AW | Port 0 word address |
| p0_rd_en | input | 1 | Port 0 read enable (registered read only) |
| p0_wr_en | input | P0_NWE | Port 0 write enable, one bit per sub-word |
| p0_wdata | input | WIDTH | Port 0 write data |
| p0_rdata | output | WIDTH | Port 0 read data |
| p1_addr | input | AW | Port 1 word address |
| p1_rd_en | input | 1 | Port 1 read enable (registered read only) |
| p1_wr_en | input | P1_NWE | Port 1 write enable, one bit per sub-word |
| p1_wdata | input | WIDTH | Port 1 write data |
| p1_rdata | output | WIDTH | Port 1 read data |

## Verification
A registered read output is due at the first rising edge after its address and enables are applied. The bench drives on the falling edge and checks the registered output at the next falling edge. It also checks once just before that edge to confirm that the old value still holds. Combinational outputs are due within the same phase and are checked 1 ns after the address changes. A write becomes visible to a combinational reader only after the edge that performs it, so the bench checks the async reader once before that edge and once at the falling edge after it. Read-during-write results appear on the same edge that performs the write, and the bench checks the written word itself with a plain read one edge later.

// File: rtl/ram_pkg.sv
// Shared definitions for the dual-port RAM: read-during-write modes and the
// rule that sizes a port's write-enable vector.
package ram_pkg;

    // What a registered read output shows while its own port writes.
    typedef enum logic [1:0] {
        RDW_READ_FIRST  = 2'd0,  // contents before the write
        RDW_WRITE_FIRST = 2'd1,  // own write data merged over old contents
        RDW_NO_CHANGE   = 2'd2   // previous output held
    } rdw_mode_e;

    // Number of write-enable bits: one per sub-word, or one for whole words.
    function automatic int unsigned we_width(input int unsigned width,
                                             input int unsigned gran);
        return (gran == 0) ? 1 : (width / gran);
    endfunction

endpackage

// File: rtl/ram_wr_mask.sv
// Expands a port's per-sub-word write enables into a per-bit write mask.
// Assumes WIDTH is a multiple of a nonzero GRAN (checked at elaboration).
// A port built without write capability yields an all-zero mask.
module ram_wr_mask #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned GRAN   = 8,
    parameter bit          HAS_WR = 1'b1,
    localparam int unsigned NWE   = ram_pkg::we_width(WIDTH, GRAN)
) (
    input  logic [NWE-1:0]   wr_en,
    output logic [WIDTH-1:0] bit_mask,
    output logic             any_write
);

    // Reject a sub-word size that does not tile the word.
    if (GRAN != 0 && (WIDTH % GRAN) != 0) begin : g_bad_gran
        $error("ram_wr_mask: WIDTH must be a multiple of a nonzero GRAN");
    end

    if (!HAS_WR) begin : g_no_write
        assign bit_mask  = '0;
        assign any_write = 1'b0;
    end else if (GRAN == 0) begin : g_whole
        assign bit_mask  = {WIDTH{wr_en[0]}};
        assign any_write = wr_en[0];
    end else begin : g_sub
        for (genvar k = 0; k < NWE; k++) begin : g_lane
            assign bit_mask[k*GRAN +: GRAN] = {GRAN{wr_en[k]}};
        end
        assign any_write = |wr_en;

        // Check that each enable bit covers exactly one sub-word of the mask.
        always_comb begin
            if (!$isunknown(wr_en)) begin
                a_r3_mask_width: assert ($countones(bit_mask) == $countones(wr_en) * GRAN)
                    else $error("a_r3_mask_width: mask popcount mismatch");
            end
        end
    end

endmodule

// File: rtl/ram_read_port.sv
// One read port of the dual-port RAM. It returns the addressed word either
// combinationally (ASYNC) or through a register that is updated at the rising
// edge, gated by an optional read enable, and resolved against this port's
// own write with the chosen read-during-write mode.
// Assumes old_word is the stored word (zero out of range) and new_word is that
// word with this port's write data merged in.
module ram_read_port #(
    parameter int unsigned        WIDTH  = 16,
    parameter bit                 ASYNC  = 1'b0,
    parameter bit                 HAS_RE = 1'b1,
    parameter ram_pkg::rdw_mode_e MODE   = ram_pkg::RDW_READ_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_active,
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] new_word,
    output logic [WIDTH-1:0] rdata
);

    if (ASYNC) begin : g_async
        // Combinational read of the current contents; enable and mode unused.
        assign rdata = old_word;
    end else begin : g_sync
        logic             rd_go;
        logic [WIDTH-1:0] rdata_q;

        // A port without a read enable reads at every edge.
        assign rd_go = !HAS_RE || rd_en;

        // Registered read with read-during-write resolution.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q <= '0;
            end else if (rd_go) begin
                if (wr_active && MODE == ram_pkg::RDW_NO_CHANGE) begin
                    rdata_q <= rdata_q;
                end else if (wr_active && MODE == ram_pkg::RDW_WRITE_FIRST) begin
                    rdata_q <= new_word;
                end else begin
                    rdata_q <= old_word;
                end
            end
        end

        assign rdata = rdata_q;

        if (HAS_RE) begin : g_re_chk
            // R6: a low read enable freezes the output.
            a_r6_re_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en |=> $stable(rdata))
                else $error("a_r6_re_hold: output moved with read enable low");
        end

        if (MODE == ram_pkg::RDW_NO_CHANGE) begin : g_nc_chk
            // R9: an own write never disturbs the output.
            a_r9_nochange_hold: assert property (@(posedge clk) disable iff (!rst_n)
                wr_active |=> $stable(rdata))
                else $error("a_r9_nochange_hold: output changed during write");
        end

        if (MODE == ram_pkg::RDW_READ_FIRST) begin : g_rf_chk
            // R7: an enabled read returns the word as stored before the edge.
            a_r7_read_first: assert property (@(posedge clk) disable iff (!rst_n)
                rd_go |=> rdata == $past(old_word))
                else $error("a_r7_read_first: output is not the pre-write word");
        end

        if (MODE == ram_pkg::RDW_WRITE_FIRST) begin : g_wf_chk
            // R8: an enabled read during an own write returns the merged word.
            a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_go && wr_active) |=> rdata == $past(new_word))
                else $error("a_r8_write_first: output is not the merged write");
        end
    end

endmodule

// File: rtl/dual_port_ram.sv
// Dual-port word RAM with per-port write granularity, read style and
// read-during-write mode. The synchronous active-low reset loads the initial
// image from INIT_VEC. Same-word writes from both ports merge per sub-word,
// and port 0 wins where both enable a sub-word. Addresses at or above DEPTH
// read as zero and drop writes.
// Assumes DEPTH >= 2 and that WIDTH is a multiple of each nonzero granularity.
module dual_port_ram #(
    parameter int unsigned        WIDTH     = 16,
    parameter int unsigned        DEPTH     = 24,
    parameter int unsigned        INIT_LEN  = 0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_VEC = '0,
    parameter int unsigned        P0_GRAN   = 8,
    parameter bit                 P0_ASYNC  = 1'b0,
    parameter bit                 P0_HAS_WR = 1'b1,
    parameter bit                 P0_HAS_RE = 1'b1,
    parameter ram_pkg::rdw_mode_e P0_MODE   = ram_pkg::RDW_READ_FIRST,
    parameter int unsigned        P1_GRAN   = 4,
    parameter bit                 P1_ASYNC  = 1'b0,
    parameter bit                 P1_HAS_WR = 1'b1,
    parameter bit                 P1_HAS_RE = 1'b1,
    parameter ram_pkg::rdw_mode_e P1_MODE   = ram_pkg::RDW_WRITE_FIRST,
    localparam int unsigned       AW        = $clog2(DEPTH),
    localparam int unsigned       P0_NWE    = ram_pkg::we_width(WIDTH, P0_GRAN),
    localparam int unsigned       P1_NWE    = ram_pkg::we_width(WIDTH, P1_GRAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     p0_addr,
    input  logic              p0_rd_en,
    input  logic [P0_NWE-1:0] p0_wr_en,
    input  logic [WIDTH-1:0]  p0_wdata,
    output logic [WIDTH-1:0]  p0_rdata,
    input  logic [AW-1:0]     p1_addr,
    input  logic              p1_rd_en,
    input  logic [P1_NWE-1:0] p1_wr_en,
    input  logic [WIDTH-1:0]  p1_wdata,
    output logic [WIDTH-1:0]  p1_rdata
);

    localparam int unsigned NPORT = 2;

    logic [WIDTH-1:0] mem      [DEPTH];
    logic [AW-1:0]    addr     [NPORT];
    logic             rd_en    [NPORT];
    logic [WIDTH-1:0] wdata    [NPORT];
    logic [WIDTH-1:0] mask     [NPORT];
    logic             any_wr   [NPORT];
    logic             in_range [NPORT];
    logic             wr_hit   [NPORT];
    logic [WIDTH-1:0] old_word [NPORT];
    logic [WIDTH-1:0] merged   [NPORT];
    logic [WIDTH-1:0] rdata    [NPORT];
    logic             same_word;
    logic [WIDTH-1:0] p0_base;
    logic [WIDTH-1:0] p0_final;

    // Gather the two ports into indexable form.
    always_comb begin
        addr[0]  = p0_addr;
        addr[1]  = p1_addr;
        rd_en[0] = p0_rd_en;
        rd_en[1] = p1_rd_en;
        wdata[0] = p0_wdata;
        wdata[1] = p1_wdata;
    end

    ram_wr_mask #(.WIDTH(WIDTH), .GRAN(P0_GRAN), .HAS_WR(P0_HAS_WR)) u_mask0 (
        .wr_en     (p0_wr_en),
        .bit_mask  (mask[0]),
        .any_write (any_wr[0])
    );

    ram_wr_mask #(.WIDTH(WIDTH), .GRAN(P1_GRAN), .HAS_WR(P1_HAS_WR)) u_mask1 (
        .wr_en     (p1_wr_en),
        .bit_mask  (mask[1]),
        .any_write (any_wr[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Range check, stored word and this port's merged write word.
        always_comb begin
            in_range[p] = ({1'b0, addr[p]} < (AW+1)'(DEPTH));
            old_word[p] = in_range[p] ? mem[addr[p]] : '0;
            wr_hit[p]   = any_wr[p] && in_range[p];
            merged[p]   = (old_word[p] & ~mask[p]) | (wdata[p] & mask[p]);
        end

        ram_read_port #(
            .WIDTH  (WIDTH),
            .ASYNC  ((p == 0) ? P0_ASYNC  : P1_ASYNC),
            .HAS_RE ((p == 0) ? P0_HAS_RE : P1_HAS_RE),
            .MODE   ((p == 0) ? P0_MODE   : P1_MODE)
        ) u_rd (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (rd_en[p]),
            .wr_active (wr_hit[p]),
            .old_word  (old_word[p]),
            .new_word  (merged[p]),
            .rdata     (rdata[p])
        );
    end

    assign p0_rdata = rdata[0];
    assign p1_rdata = rdata[1];

    // Port 0 merges on top of port 1's result when both hit one word.
    always_comb begin
        same_word = wr_hit[0] && wr_hit[1] && (addr[0] == addr[1]);
        p0_base   = same_word ? merged[1] : old_word[0];
        p0_final  = (p0_base & ~mask[0]) | (wdata[0] & mask[0]);
    end

    // Storage: load the image in reset, otherwise apply the two writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < INIT_LEN) ? INIT_VEC[i*WIDTH +: WIDTH] : '0;
            end
        end else begin
            if (wr_hit[1]) begin
                mem[addr[1]] <= merged[1];
            end
            if (wr_hit[0]) begin
                mem[addr[0]] <= p0_final;
            end
        end
    end

    // R11: a full port 0 write to a shared word leaves exactly port 0's data.
    a_r11_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (same_word && (&mask[0])) |=> mem[$past(addr[0])] == $past(p0_wdata))
        else $error("a_r11_port0_wins: port 0 lost a same-word collision");

endmodule

// File: tb/tb_dual_port_ram.sv
`timescale 1ns/1ps
// Directed bench: dut uses masked registered ports (read-before-write on
// port 0, write-through on port 1); dut_alt uses a whole-word hold-mode port 0
// without read enable and a read-only combinational port 1.
module tb_dual_port_ram;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    localparam logic [24*16-1:0] IMG_A = {352'h0, 16'hABCD, 16'h1234};
    localparam logic [24*16-1:0] IMG_B = {368'h0, 16'hC0DE};

    logic [4:0]  p0_addr, p1_addr, q0_addr, q1_addr;
    logic        p0_rd_en, p1_rd_en, q0_rd_en, q1_rd_en;
    logic [1:0]  p0_wr_en;
    logic [3:0]  p1_wr_en;
    logic [0:0]  q0_wr_en, q1_wr_en;
    logic [15:0] p0_wdata, p1_wdata, q0_wdata, q1_wdata;
    logic [15:0] p0_rdata, p1_rdata, q0_rdata, q1_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    dual_port_ram #(.INIT_LEN(2), .INIT_VEC(IMG_A)) dut (
        .clk(clk), .rst_n(rst_n),
        .p0_addr(p0_addr), .p0_rd_en(p0_rd_en), .p0_wr_en(p0_wr_en),
        .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_addr(p1_addr), .p1_rd_en(p1_rd_en), .p1_wr_en(p1_wr_en),
        .p1_wdata(p1_wdata), .p1_rdata(p1_rdata)
    );

    dual_port_ram #(
        .INIT_LEN(1), .INIT_VEC(IMG_B),
        .P0_GRAN(0), .P0_HAS_RE(1'b0), .P0_MODE(ram_pkg::RDW_NO_CHANGE),
        .P1_GRAN(0), .P1_ASYNC(1'b1), .P1_HAS_WR(1'b0)
    ) dut_alt (
        .clk(clk), .rst_n(rst_n),
        .p0_addr(q0_addr), .p0_rd_en(q0_rd_en), .p0_wr_en(q0_wr_en),
        .p0_wdata(q0_wdata), .p0_rdata(q0_rdata),
        .p1_addr(q1_addr), .p1_rd_en(q1_rd_en), .p1_wr_en(q1_wr_en),
        .p1_wdata(q1_wdata), .p1_rdata(q1_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        p0_wr_en = '0; p1_wr_en = '0; q0_wr_en = '0; q1_wr_en = '0;
        p0_rd_en = 1'b1; p1_rd_en = 1'b1; q0_rd_en = 1'b1; q1_rd_en = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) step();
        check("R1 p0 zero in reset", p0_rdata, 16'h0000);
        check("R1 p1 zero in reset", p1_rdata, 16'h0000);
        check("R1 alt p0 zero in reset", q0_rdata, 16'h0000);
        rst_n = 1'b1;
        p0_addr = 5'd0; p1_addr = 5'd1; q0_addr = 5'd5; q1_addr = 5'd0;
        step();
        check("R1 image word 0", p0_rdata, 16'h1234);
        check("R1 image word 1", p1_rdata, 16'hABCD);
        check("R1 uncovered word zero", q0_rdata, 16'h0000);
        check("R1 alt image word 0", q1_rdata, 16'hC0DE);
    endtask

    task automatic t_latency();
        p0_addr = 5'd1;
        #1 check("R4 holds before edge", p0_rdata, 16'h1234);
        step();
        check("R4 updates after edge", p0_rdata, 16'hABCD);
    endtask

    task automatic t_read_enable();
        p0_rd_en = 1'b0; p0_addr = 5'd0;
        step();
        check("R6 hold with enable low", p0_rdata, 16'hABCD);
        p0_rd_en = 1'b1;
        q0_rd_en = 1'b0; q0_addr = 5'd0;
        step();
        check("R6 no-enable port still reads", q0_rdata, 16'hC0DE);
        q0_rd_en = 1'b1;
    endtask

    task automatic t_masked();
        p0_addr = 5'd2; p0_wdata = 16'hFFFF; p0_wr_en = 2'b01;
        step();
        p0_wr_en = '0;
        p1_addr = 5'd2; p1_wdata = 16'hABCD; p1_wr_en = 4'b1000;
        step();
        check("R8 write-through merge", p1_rdata, 16'hA0FF);
        p1_wr_en = '0;
        step();
        check("R3 sub-word writes combine", p0_rdata, 16'hA0FF);
    endtask

    task automatic t_read_first();
        p0_addr = 5'd4; p0_wdata = 16'h1111; p0_wr_en = 2'b11;
        step();
        check("R7 old word during write", p0_rdata, 16'h0000);
        p0_wr_en = '0;
        step();
        check("R7 new word afterwards", p0_rdata, 16'h1111);
    endtask

    task automatic t_write_first();
        p1_addr = 5'd4; p1_wdata = 16'h2222; p1_wr_en = 4'b0011;
        step();
        check("R8 own data in low nibbles", p1_rdata, 16'h1122);
        p1_wr_en = '0;
    endtask

    task automatic t_whole_and_hold();
        q0_addr = 5'd3; q0_wdata = 16'h5A5A; q0_wr_en = 1'b1;
        step();
        check("R9 hold during write", q0_rdata, 16'hC0DE);
        q0_wr_en = 1'b0;
        step();
        check("R2 whole word written", q0_rdata, 16'h5A5A);
        q0_addr = 5'd6; q0_wdata = 16'h7777; q0_wr_en = 1'b1;
        step();
        check("R9 hold on second write", q0_rdata, 16'h5A5A);
        q0_wr_en = 1'b0;
        step();
        check("R2 second word written", q0_rdata, 16'h7777);
    endtask

    task automatic t_async();
        q1_addr = 5'd6;
        #1 check("R5 combinational read", q1_rdata, 16'h7777);
        q1_addr = 5'd7; q0_addr = 5'd7; q0_wdata = 16'h1357; q0_wr_en = 1'b1;
        #1 check("R5 before write edge", q1_rdata, 16'h0000);
        step();
        check("R5 after write edge", q1_rdata, 16'h1357);
        q0_wr_en = 1'b0;
    endtask

    task automatic t_range();
        p0_addr = 5'd30; p0_wdata = 16'hFFFF; p0_wr_en = 2'b11;
        step();
        p0_wr_en = '0;
        step();
        check("R10 out of range reads zero", p0_rdata, 16'h0000);
        p0_addr = 5'd6;
        step();
        check("R10 dropped write no alias", p0_rdata, 16'h0000);
        q1_addr = 5'd25;
        #1 check("R10 async out of range zero", q1_rdata, 16'h0000);
    endtask

    task automatic t_collide();
        p0_addr = 5'd8; p0_wdata = 16'hAAAA; p0_wr_en = 2'b01;
        p1_addr = 5'd8; p1_wdata = 16'h5555; p1_wr_en = 4'b1111;
        step();
        p0_wr_en = '0; p1_wr_en = '0;
        step();
        check("R11 port 0 wins shared byte", p0_rdata, 16'h55AA);
    endtask

    task automatic t_cross();
        p0_addr = 5'd9; p0_wdata = 16'h9999; p0_wr_en = 2'b11;
        p1_addr = 5'd9;
        step();
        check("R12 other port sees old word", p1_rdata, 16'h0000);
        p0_wr_en = '0;
        step();
        check("R12 other port sees new word", p1_rdata, 16'h9999);
    endtask

    task automatic t_no_write();
        q1_addr = 5'd0; q1_wdata = 16'hFFFF; q1_wr_en = 1'b1;
        step();
        check("R13 read-only port ignores write", q1_rdata, 16'hC0DE);
        q1_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        idle();
        p0_addr = '0; p1_addr = '0; q0_addr = '0; q1_addr = '0;
        p0_wdata = '0; p1_wdata = '0; q0_wdata = '0; q1_wdata = '0;
        t_reset();
        t_latency();
        t_read_enable();
        t_masked();
        t_read_first();
        t_write_first();
        t_whole_and_hold();
        t_async();
        t_range();
        t_collide();
        t_cross();
        t_no_write();
        step();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule